// File: doc/BRIEF.md
# General-Purpose I/O Bank with Grouped Falling-Edge Interrupts

This block holds five 8-bit general-purpose ports behind a small register interface. Each port has a direction register and an output data register. Every port except port 0 also has a pull-up enable register. Port 0 drives as open-drain: it can only pull a pad low or release it. The other ports drive push-pull. The block presents output-enable, output value and pull-up enable for every pad. It takes the raw pad levels in and passes them through a two-flop synchronizer.

The eight pins of port 1 also feed two grouped interrupt sources: the low nibble is one group and the high nibble is the other. An enable register holds one bit per port-1 pin and selects which pins can raise their group's flag. A falling edge on an enabled pin sets the flag of its group. The flag stays set until software clears it. The two flag levels leave the block as interrupt requests.

Register address layout: address bits [4:3] pick a group, and bits [2:0] pick a port index. Group 0 holds the data registers, group 1 the direction registers, group 2 the pull-up registers, and group 3 the controls (index 0 is the interrupt enable, index 1 is the flags). Reads are combinational from the address.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pad output-enable and pull-up enable is 0, both interrupt flags and the enable register are 0, and all direction registers read 0. The output data registers of ports 0 to 3 hold FFh and port 4 holds 00h.
- R2: A write at address {grp,idx} updates that register on the next clock. Direction (grp 1) and pull-up (grp 2) registers read back what was written.
- R3: For ports 1 to 4, a pad's output-enable equals its direction bit (1 = output), and its output value equals its data register bit.
- R4: For port 0, the pad is driven low (output-enable 1, output value 0) only when the direction bit is 1 and the data bit is 0. In every other case output-enable is 0, and the output value is always 0.
- R5: Port 0 has no pull-up register: writes to address 10h are ignored, the address reads 00h, and the port-0 pull-up outputs stay 0.
- R6: The pull-up outputs of ports 1 to 4 follow their pull-up register bits.
- R7: Reading a data register (grp 0) returns the latched output bit for output pins and the pad level for input pins. The pad level is delayed by two clocks of synchronization.
- R8: A falling edge on an enabled port-1 pin 0..3 sets flag bit 0 (irq_lo). The same on pin 4..7 sets flag bit 1 (irq_hi). The flag rises on the third clock edge after the pad changes. The flags read at address 19h, bits [1:0].
- R9: Falling edges on pins whose enable bit (address 18h, bit n = port-1 pin n) is 0 set no flag, and rising edges on enabled pins set no flag.
- R10: A flag stays set until a write to 19h carries 0 in its bit. A 1 in that bit leaves the flag unchanged.
- R11: When an enabled falling edge and a clearing write reach the same flag on the same clock edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address {group, index} |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 40 | Pad levels, port p at bits [8p+7:8p] |
| pad_oe | output | 40 | Pad output-enable |
| pad_out | output | 40 | Pad output value |
| pad_pu | output | 40 | Pad pull-up enable |
| irq_lo | output | 1 | Flag of port-1 pins 0..3 |
| irq_hi | output | 1 | Flag of port-1 pins 4..7 |

## Verification
The hardest case to reach is a flag-clearing write that lands on the same clock edge as the internal edge detection of a new falling edge. That detection fires two synchronizer stages after the pad moves. The stimulus first sets the flag and returns the pin high. It then drops the pin and issues the clearing write exactly two clocks later, so that the write commits on the same edge the flag would be set. The flag must read set afterwards. A plain clear that follows must then drop it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Register group selected by the upper address bits
    typedef enum logic [1:0] {
        GRP_DATA = 2'd0,
        GRP_DIR  = 2'd1,
        GRP_PU   = 2'd2,
        GRP_CTL  = 2'd3
    } reg_grp_e;

    // Index of the control registers within GRP_CTL
    localparam int CTL_IDX_EN   = 0;
    localparam int CTL_IDX_FLAG = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] st1;
        logic [W-1:0] st2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.st1 = raw_in;
        s_d.st2 = s_q.st1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.st2;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int           PW         = 8,
    parameter bit           OPEN_DRAIN = 1'b0,
    parameter bit           HAS_PU     = 1'b1,
    parameter logic [PW-1:0] RST_DATA  = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic          wr_dir,
    input  logic          wr_pu,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pad_sync,
    output logic [PW-1:0] rd_data,
    output logic [PW-1:0] rd_dir,
    output logic [PW-1:0] rd_pu,
    output logic [PW-1:0] pad_oe,
    output logic [PW-1:0] pad_out,
    output logic [PW-1:0] pad_pu
);
    typedef struct packed {
        logic [PW-1:0] dout;
        logic [PW-1:0] dir;
        logic [PW-1:0] pu;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (wr_data) p_d.dout = wdata;
        if (wr_dir)  p_d.dir  = wdata;
        if (HAS_PU) begin
            if (wr_pu) p_d.pu = wdata;
        end else begin
            p_d.pu = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.dout <= RST_DATA;
            p_q.dir  <= '0;
            p_q.pu   <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    generate
        if (OPEN_DRAIN) begin : g_od
            assign pad_oe  = p_q.dir & ~p_q.dout;
            assign pad_out = '0;
        end else begin : g_pp
            assign pad_oe  = p_q.dir;
            assign pad_out = p_q.dout;
        end
    endgenerate

    assign pad_pu  = p_q.pu;
    assign rd_dir  = p_q.dir;
    assign rd_pu   = p_q.pu;
    assign rd_data = (p_q.dir & p_q.dout) | (~p_q.dir & pad_sync);

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (rd_dir == $past(wdata)));

    // R3
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (p_q.dout == $past(wdata)));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_flag,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pin_sync,
    output logic [PW-1:0] en_out,
    output logic [1:0]    flag_out
);
    localparam int HALF = PW / 2;

    typedef struct packed {
        logic [PW-1:0] en;
        logic [PW-1:0] prev;
        logic [1:0]    flag;
    } irq_t;

    irq_t          r_d, r_q;
    logic [PW-1:0] fall;
    logic [1:0]    hit;

    assign fall = r_q.prev & ~pin_sync;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_grp
            assign hit[g] = |(fall[g*HALF +: HALF] & r_q.en[g*HALF +: HALF]);
        end
    endgenerate

    always_comb begin
        r_d      = r_q;
        r_d.prev = pin_sync;
        if (wr_en) r_d.en = wdata;
        for (int g = 0; g < 2; g++) begin
            if (wr_flag && !wdata[g]) r_d.flag[g] = 1'b0;
            if (hit[g])               r_d.flag[g] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_out   = r_q.en;
    assign flag_out = r_q.flag;

    // R8
    lo_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_out[0]) |-> $past(|(fall[HALF-1:0] & r_q.en[HALF-1:0])));

    // R10
    lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_out[0] && !(wr_flag && !wdata[0])) |=> flag_out[0]);

    // R10
    hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_out[1] && !(wr_flag && !wdata[1])) |=> flag_out[1]);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && wr_flag && !wdata[0]) |=> flag_out[0]);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NPORTS    = 5,
    parameter int PW        = 8,
    parameter int FF_PORTS  = 4,
    parameter int OD_PORT   = 0,
    parameter int IRQ_PORT  = 1,
    localparam int IDX_W    = $clog2(NPORTS),
    localparam int ADDR_W   = IDX_W + 2,
    localparam int TW       = NPORTS * PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PW-1:0]     bus_wdata,
    output logic [PW-1:0]     bus_rdata,
    input  logic [TW-1:0]     pad_in,
    output logic [TW-1:0]     pad_oe,
    output logic [TW-1:0]     pad_out,
    output logic [TW-1:0]     pad_pu,
    output logic              irq_lo,
    output logic              irq_hi
);
    reg_grp_e         grp;
    logic [IDX_W-1:0] idx;
    logic [TW-1:0]    pad_sync;
    logic [PW-1:0]    rd_data [NPORTS];
    logic [PW-1:0]    rd_dir  [NPORTS];
    logic [PW-1:0]    rd_pu   [NPORTS];
    logic [PW-1:0]    irq_en;
    logic [1:0]       irq_flag;
    logic             wr_en, wr_flag;

    assign grp = reg_grp_e'(bus_addr[ADDR_W-1 -: 2]);
    assign idx = bus_addr[IDX_W-1:0];

    gpio_sync #(.W(TW)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .sync_out (pad_sync)
    );

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            logic wr_d, wr_r, wr_p;
            assign wr_d = bus_wr && (grp == GRP_DATA) && (idx == IDX_W'(p));
            assign wr_r = bus_wr && (grp == GRP_DIR)  && (idx == IDX_W'(p));
            assign wr_p = bus_wr && (grp == GRP_PU)   && (idx == IDX_W'(p));

            gpio_port #(
                .PW         (PW),
                .OPEN_DRAIN (p == OD_PORT),
                .HAS_PU     (p != OD_PORT),
                .RST_DATA   ((p < FF_PORTS) ? {PW{1'b1}} : {PW{1'b0}})
            ) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_data  (wr_d),
                .wr_dir   (wr_r),
                .wr_pu    (wr_p),
                .wdata    (bus_wdata),
                .pad_sync (pad_sync[p*PW +: PW]),
                .rd_data  (rd_data[p]),
                .rd_dir   (rd_dir[p]),
                .rd_pu    (rd_pu[p]),
                .pad_oe   (pad_oe[p*PW +: PW]),
                .pad_out  (pad_out[p*PW +: PW]),
                .pad_pu   (pad_pu[p*PW +: PW])
            );
        end
    endgenerate

    assign wr_en   = bus_wr && (grp == GRP_CTL) && (idx == IDX_W'(CTL_IDX_EN));
    assign wr_flag = bus_wr && (grp == GRP_CTL) && (idx == IDX_W'(CTL_IDX_FLAG));

    gpio_irq #(.PW(PW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_flag  (wr_flag),
        .wdata    (bus_wdata),
        .pin_sync (pad_sync[IRQ_PORT*PW +: PW]),
        .en_out   (irq_en),
        .flag_out (irq_flag)
    );

    always_comb begin
        bus_rdata = '0;
        case (grp)
            GRP_DATA: for (int p = 0; p < NPORTS; p++)
                          if (idx == IDX_W'(p)) bus_rdata = rd_data[p];
            GRP_DIR:  for (int p = 0; p < NPORTS; p++)
                          if (idx == IDX_W'(p)) bus_rdata = rd_dir[p];
            GRP_PU:   for (int p = 0; p < NPORTS; p++)
                          if (idx == IDX_W'(p)) bus_rdata = rd_pu[p];
            default: begin
                if (idx == IDX_W'(CTL_IDX_EN))   bus_rdata = irq_en;
                if (idx == IDX_W'(CTL_IDX_FLAG)) bus_rdata = {{(PW-2){1'b0}}, irq_flag};
            end
        endcase
    end

    assign irq_lo = irq_flag[0];
    assign irq_hi = irq_flag[1];

    // R5
    od_no_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pu[OD_PORT*PW +: PW] == '0);

    // R4
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_oe[OD_PORT*PW]) |-> !rd_data[OD_PORT][0] || !rd_dir[OD_PORT][0] || !pad_out[OD_PORT*PW]);
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [39:0] pad_in = '1;
    logic [39:0] pad_oe, pad_out, pad_pu;
    logic        irq_lo, irq_hi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // sel: 0 rdata, 1 oe, 2 out, 3 pull-up, 4 {irq_hi,irq_lo}
    typedef struct {
        int         sel;
        int         port;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    event  chk_ev;

    function automatic logic [7:0] actual(int sel, int port);
        case (sel)
            0: return bus_rdata;
            1: return pad_oe[port*8 +: 8];
            2: return pad_out[port*8 +: 8];
            3: return pad_pu[port*8 +: 8];
            default: return {6'd0, irq_hi, irq_lo};
        endcase
    endfunction

    // monitor: pops expected items and compares
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] a;
                it = q.pop_front();
                a = actual(it.sel, it.port);
                n_chk++;
                if (a !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d port=%0d actual=%02h expected=%02h",
                             it.tag, it.sel, it.port, a, it.exp);
                end
            end
        end
    end

    task automatic expect_sig(int sel, int port, logic [7:0] exp, string tag);
        item_t it;
        it.sel = sel; it.port = port; it.exp = exp; it.tag = tag;
        q.push_back(it);
        -> chk_ev;
        wait (q.size() == 0);
    endtask

    task automatic expect_rd(logic [4:0] addr, logic [7:0] exp, string tag);
        bus_addr = addr;
        #1;
        expect_sig(0, 0, exp, tag);
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] addr, logic [7:0] data);
        bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        for (int p = 0; p < 5; p++) begin
            expect_sig(1, p, 8'h00, "R1 oe");
            expect_sig(3, p, 8'h00, "R1 pu");
        end
        expect_sig(4, 0, 8'h00, "R1 flags");
        for (int p = 0; p < 5; p++) expect_rd(5'h08 + 5'(p), 8'h00, "R1 dir");
        expect_rd(5'h18, 8'h00, "R1 enable");
        // reveal reset data values by switching all to output
        for (int p = 0; p < 5; p++) wr(5'h08 + 5'(p), 8'hFF);
        for (int p = 1; p < 4; p++) expect_sig(2, p, 8'hFF, "R1 data FF");
        expect_sig(2, 4, 8'h00, "R1 port4 data");
        expect_sig(1, 0, 8'h00, "R1 port0 released");
        // R3 push-pull
        wr(5'h02, 8'hA5);
        expect_sig(2, 2, 8'hA5, "R3 out");
        expect_sig(1, 2, 8'hFF, "R3 oe");
        wr(5'h0B, 8'h0F);
        wr(5'h03, 8'h3C);
        expect_sig(1, 3, 8'h0F, "R3 oe partial");
        expect_sig(2, 3, 8'h3C, "R3 out p3");
        // R4 open drain
        wr(5'h00, 8'h5A);
        expect_sig(1, 0, 8'hA5, "R4 oe");
        expect_sig(2, 0, 8'h00, "R4 out");
        wr(5'h08, 8'h0F);
        expect_sig(1, 0, 8'h05, "R4 oe dir");
        // R2 / R6
        expect_rd(5'h0B, 8'h0F, "R2 dir readback");
        wr(5'h14, 8'hC3);
        expect_rd(5'h14, 8'hC3, "R2 pu readback");
        expect_sig(3, 4, 8'hC3, "R6 pu p4");
        wr(5'h11, 8'h81);
        expect_sig(3, 1, 8'h81, "R6 pu p1");
        // R5
        wr(5'h10, 8'hFF);
        expect_rd(5'h10, 8'h00, "R5 read");
        expect_sig(3, 0, 8'h00, "R5 pu p0");
        // R7 read mix of output latch and pad
        expect_rd(5'h03, 8'hFC, "R7 before");
        pad_in[31:24] = 8'hA5;
        cycles(2);
        expect_rd(5'h03, 8'hAC, "R7 after sync");
        // R8 low group, pins 0 and 4 enabled
        wr(5'h18, 8'h11);
        pad_in[8] = 1'b0;
        cycles(2);
        expect_sig(4, 0, 8'h00, "R8 not yet");
        cycles(1);
        expect_sig(4, 0, 8'h01, "R8 lo set");
        expect_rd(5'h19, 8'h01, "R8 flag read");
        // R9 disabled pins
        pad_in[9]  = 1'b0;
        pad_in[13] = 1'b0;
        cycles(4);
        expect_sig(4, 0, 8'h01, "R9 disabled");
        // R8 high group
        pad_in[12] = 1'b0;
        cycles(3);
        expect_sig(4, 0, 8'h03, "R8 hi set");
        // R10 selective clear
        wr(5'h19, 8'h02);
        expect_sig(4, 0, 8'h02, "R10 clear lo");
        cycles(3);
        expect_sig(4, 0, 8'h02, "R10 sticky");
        wr(5'h19, 8'h01);
        expect_sig(4, 0, 8'h00, "R10 clear hi");
        // R9 rising edge on enabled pin
        pad_in[12] = 1'b1;
        cycles(4);
        expect_sig(4, 0, 8'h00, "R9 rising");
        // R11 coincidence: set lo, return high, fall again with clear on same edge
        pad_in[8] = 1'b1;
        cycles(4);
        pad_in[8] = 1'b0;
        cycles(3);
        expect_sig(4, 0, 8'h01, "R11 pre-set");
        pad_in[8] = 1'b1;
        cycles(4);
        pad_in[8] = 1'b0;
        cycles(2);
        wr(5'h19, 8'h00);
        expect_sig(4, 0, 8'h01, "R11 set wins");
        wr(5'h19, 8'h00);
        expect_sig(4, 0, 8'h00, "R10 plain clear");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule